// File: doc/BRIEF.md
# Boot-Overlay Memory and Cycle Decoder

This block is the address and cycle glue for a processor with a 20-bit byte address and an asynchronous bus. On each bus cycle it takes the active-low address strobe, the write line and the upper address bits. From them it produces the RAM and ROM chip enables, a read strobe, a data-acknowledge output and a slow-peripheral acknowledge output. The address space has three regions. RAM sits at 0x00000–0x3FFFF and ROM at 0x40000–0x7FFFF. Every address with the top bit set belongs to I/O space.

The block keeps a one-bit boot flag. Reset sets the flag, and while it is set any access that lands in the RAM region enables the ROM instead. The processor can therefore fetch its reset vectors from ROM at address zero. The first strobed access to I/O space clears the flag on the following clock edge. From then on RAM occupies the bottom of the map and software can rewrite the vector table.

Address bit 14 picks between fast and slow I/O. It sits in the low address word, so I/O addresses in the short, sign-extended form still reach both kinds. An interrupt-acknowledge cycle drives all upper bits high, so bit 14 is high and the cycle stays fast, ending through data-acknowledge. No bus error is ever raised. Every cycle ends either through data-acknowledge or through slow-peripheral acknowledge.

Top module: `boot_overlay_decoder`

## Requirements
- R1: With the boot flag clear and the strobe active, an address with bit19=0 and bit18=0 drives ram_ce_n low and rom_ce_n high.
- R2: With the strobe active, an address with bit19=0 and bit18=1 drives rom_ce_n low and ram_ce_n high, whatever the state of the boot flag.
- R3: After reset the boot flag is set, and a strobed access in the RAM region drives rom_ce_n low while ram_ce_n stays high.
- R4: A strobed access with bit19=1 while the flag is set clears the flag at the next rising clock edge. RAM-region accesses after that edge enable RAM.
- R5: While as_n is high, ram_ce_n, rom_ce_n and vpa_n are all high. An I/O address presented without the strobe leaves the boot flag set.
- R6: vpa_n is low exactly when the strobe is active, bit19=1 and bit14=0.
- R7: An interrupt-acknowledge address (bits 19 down to 4 all 1) never drives vpa_n low.
- R8: dtack_n is low except while vpa_n is low or the wait request wait_n is low.
- R9: rd_n is always the inverse of wr_n.
- R10: Asserting rst_n sets the boot flag even during a strobed I/O access. Reset wins over clear, and the flag stays set until a strobed I/O access occurs after reset release has passed the two-stage synchronizer.
- R11: A strobed access with bit19=1 never drives ram_ce_n or rom_ce_n low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the boot flag and the reset synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| as_n | input | 1 | Active-low address strobe from the processor |
| wr_n | input | 1 | Active-low write line from the processor |
| addr | input | 20 | Processor byte address |
| wait_n | input | 1 | Active-low wait request from the peripheral bus |
| ram_ce_n | output | 1 | Active-low RAM chip enable |
| rom_ce_n | output | 1 | Active-low ROM enable |
| rd_n | output | 1 | Active-low read strobe |
| dtack_n | output | 1 | Active-low data-acknowledge to the processor |
| vpa_n | output | 1 | Active-low slow-peripheral acknowledge to the processor |

## Verification
The assertions assume the address and write line hold steady while as_n is low within a clock period. They also assume the flag-clearing check only fires after the synchronized reset has been released. The stimulus meets these assumptions: every input changes once per period, at the falling clock edge. Reset release is followed by idle cycles with the strobe high before any I/O access. The case where reset collides with a pending I/O access is driven on purpose, and it is checked only through the enables seen afterwards.

// File: rtl/bod_pkg.sv
package bod_pkg;
  typedef enum logic [1:0] {
    REG_RAM = 2'd0,
    REG_ROM = 2'd1,
    REG_IO  = 2'd2
  } region_e;
endpackage

// File: rtl/bod_reset_sync.sv
module bod_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/bod_region_dec.sv
module bod_region_dec
  import bod_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam int TOP = ADDR_W - 1;
  localparam int SUB = ADDR_W - 2;

  always_comb begin
    if (addr[TOP])      region = REG_IO;
    else if (addr[SUB]) region = REG_ROM;
    else                region = REG_RAM;
  end
endmodule

// File: rtl/bod_boot_flag.sv
module bod_boot_flag (
  input  logic clk,
  input  logic rst_q_n,
  input  logic clr_req,
  output logic boot
);
  logic boot_en, boot_d;

  always_comb begin
    boot_en = clr_req;
    boot_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     boot <= 1'b1;
    else if (boot_en) boot <= boot_d;
  end
endmodule

// File: rtl/bod_mem_select.sv
module bod_mem_select
  import bod_pkg::*;
(
  input  logic    as_act,
  input  region_e region,
  input  logic    boot,
  output logic    ram_ce_n,
  output logic    rom_ce_n,
  output logic    io_hit
);
  always_comb begin
    ram_ce_n = 1'b1;
    rom_ce_n = 1'b1;
    io_hit   = 1'b0;
    if (as_act) begin
      unique case (region)
        REG_RAM: begin
          if (boot) rom_ce_n = 1'b0;
          else      ram_ce_n = 1'b0;
        end
        REG_ROM: rom_ce_n = 1'b0;
        REG_IO:  io_hit   = 1'b1;
        default: io_hit   = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bod_cycle_term.sv
module bod_cycle_term (
  input  logic as_act,
  input  logic io_space,
  input  logic slow_sel,
  input  logic wait_n,
  output logic vpa_n,
  output logic dtack_n
);
  logic slow_act;

  always_comb begin
    slow_act = as_act & io_space & ~slow_sel;
    vpa_n    = ~slow_act;
    dtack_n  = slow_act | ~wait_n;
  end
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import bod_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int SLOW_BIT    = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wait_n,
  output logic              ram_ce_n,
  output logic              rom_ce_n,
  output logic              rd_n,
  output logic              dtack_n,
  output logic              vpa_n
);
  localparam int TOP = ADDR_W - 1;
  localparam int SUB = ADDR_W - 2;

  logic    rst_q_n;
  logic    boot;
  logic    as_act;
  logic    io_hit;
  logic    clr_req;
  region_e region;

  assign as_act = ~as_n;
  assign rd_n   = ~wr_n;

  bod_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  bod_region_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (addr),
    .region (region)
  );

  bod_mem_select u_sel (
    .as_act   (as_act),
    .region   (region),
    .boot     (boot),
    .ram_ce_n (ram_ce_n),
    .rom_ce_n (rom_ce_n),
    .io_hit   (io_hit)
  );

  // clear term: I/O space with either the sub-bit or the flag itself high
  assign clr_req = io_hit & (addr[SUB] | boot);

  bod_boot_flag u_flag (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .clr_req (clr_req),
    .boot    (boot)
  );

  bod_cycle_term u_term (
    .as_act   (as_act),
    .io_space (addr[TOP]),
    .slow_sel (addr[SLOW_BIT]),
    .wait_n   (wait_n),
    .vpa_n    (vpa_n),
    .dtack_n  (dtack_n)
  );
endmodule

// File: rtl/boot_overlay_decoder_chk.sv
module boot_overlay_decoder_chk (
  input logic        clk,
  input logic        rst_q_n,
  input logic        as_n,
  input logic        wr_n,
  input logic [19:0] addr,
  input logic        ram_ce_n,
  input logic        rom_ce_n,
  input logic        rd_n,
  input logic        dtack_n,
  input logic        vpa_n
);
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    as_n |-> (ram_ce_n && rom_ce_n && vpa_n));

  // R2
  rom_region_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!as_n && addr[19:18] == 2'b01) |-> (!rom_ce_n && ram_ce_n));

  // R11
  io_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!as_n && addr[19]) |-> (ram_ce_n && rom_ce_n));

  // R7
  fast_io_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!as_n && addr[19] && addr[14]) |-> vpa_n);

  // R8
  slow_blocks_dtack_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !vpa_n |-> dtack_n);

  // R9
  rd_wr_opposite_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    rd_n != wr_n);

  // R4
  ram_after_io_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!as_n && addr[19]) ##1 (!as_n && addr[19:18] == 2'b00) |-> (!ram_ce_n && rom_ce_n));

  // R3
  single_mem_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(!ram_ce_n && !rom_ce_n));
endmodule

bind boot_overlay_decoder boot_overlay_decoder_chk u_chk (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .as_n     (as_n),
  .wr_n     (wr_n),
  .addr     (addr),
  .ram_ce_n (ram_ce_n),
  .rom_ce_n (rom_ce_n),
  .rd_n     (rd_n),
  .dtack_n  (dtack_n),
  .vpa_n    (vpa_n)
);

// File: tb/boot_overlay_decoder_test.sv
module boot_overlay_decoder_test;
  logic        clk;
  logic        rst_n;
  logic        as_n;
  logic        wr_n;
  logic [19:0] addr;
  logic        wait_n;
  logic        ram_ce_n, rom_ce_n, rd_n, dtack_n, vpa_n;

  int checks = 0;
  int errors = 0;
  int boot_m;     // reference boot flag
  int rel_cnt;    // edges seen since reset release
  bit done = 0;

  boot_overlay_decoder uut (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .wr_n(wr_n), .addr(addr),
    .wait_n(wait_n), .ram_ce_n(ram_ce_n), .rom_ce_n(rom_ce_n),
    .rd_n(rd_n), .dtack_n(dtack_n), .vpa_n(vpa_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // reference flag update on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_m  = 1;
      rel_cnt = 0;
    end else begin
      if (rel_cnt >= 2 && !as_n && addr[19] && (addr[18] || boot_m == 1))
        boot_m = 0;
      if (rel_cnt < 2) rel_cnt = rel_cnt + 1;
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Compare all outputs against the model, mid low phase
  task automatic compare(input string tag);
    logic as_a, io, ram_e, rom_e, slow;
    as_a  = !as_n;
    io    = addr[19];
    ram_e = as_a && !io && !addr[18] && boot_m == 0;
    rom_e = as_a && !io && (addr[18] || boot_m == 1);
    slow  = as_a && io && !addr[14];
    chk(tag, "ram_ce_n", ram_ce_n, !ram_e);
    chk(tag, "rom_ce_n", rom_ce_n, !rom_e);
    chk(tag, "vpa_n",    vpa_n,    !slow);
    chk(tag, "dtack_n",  dtack_n,  slow || !wait_n);
    chk(tag, "rd_n",     rd_n,     !wr_n);
  endtask

  task automatic cyc(input string tag, input logic a_n, input logic w_n,
                     input logic [19:0] a, input logic wt_n);
    @(negedge clk);
    as_n = a_n; wr_n = w_n; addr = a; wait_n = wt_n;
    #5;
    compare(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc("R5", 1'b1, 1'b1, 20'h00000, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; as_n = 1'b1; wr_n = 1'b1; addr = '0; wait_n = 1'b1;
    boot_m = 1; rel_cnt = 0;
    repeat (3) @(posedge clk);
    #5 compare("R3 reset");
    @(negedge clk) rst_n = 1'b1;
    idle(4);
    // R3: boot overlay, RAM region reads ROM
    cyc("R3", 1'b0, 1'b1, 20'h00000, 1'b1);
    cyc("R3", 1'b0, 1'b1, 20'h00004, 1'b1);
    cyc("R3", 1'b0, 1'b0, 20'h3FFFF, 1'b1);
    // R2: ROM region
    cyc("R2", 1'b0, 1'b1, 20'h40000, 1'b1);
    cyc("R2", 1'b0, 1'b1, 20'h7FFFF, 1'b1);
    // R5: I/O address without strobe leaves flag set
    cyc("R5", 1'b1, 1'b1, 20'hF8000, 1'b1);
    cyc("R5", 1'b0, 1'b1, 20'h00010, 1'b1);
    // R9 both polarities
    cyc("R9", 1'b1, 1'b0, 20'h00000, 1'b1);
    cyc("R9", 1'b1, 1'b1, 20'h00000, 1'b1);
    // R7: interrupt acknowledge while still booting, fast and clears flag
    cyc("R7", 1'b0, 1'b1, 20'hFFFF5, 1'b1);
    // R4: RAM now enabled
    cyc("R4", 1'b0, 1'b1, 20'h00000, 1'b1);
    cyc("R1", 1'b0, 1'b0, 20'h1234A, 1'b1);
    cyc("R1", 1'b0, 1'b1, 20'h3FFFF, 1'b1);
    cyc("R2", 1'b0, 1'b1, 20'h5A5A5, 1'b1);
    // R6 / R11: slow and fast I/O
    cyc("R6", 1'b0, 1'b1, 20'hF8003, 1'b1);
    cyc("R6", 1'b0, 1'b0, 20'h80000, 1'b1);
    cyc("R6", 1'b0, 1'b1, 20'hC4000, 1'b1);
    cyc("R11", 1'b0, 1'b0, 20'hFC007, 1'b1);
    cyc("R6", 1'b1, 1'b1, 20'h80000, 1'b1);
    // R8: wait request
    cyc("R8", 1'b0, 1'b1, 20'h00100, 1'b0);
    cyc("R8", 1'b1, 1'b1, 20'h00000, 1'b0);
    cyc("R8", 1'b0, 1'b1, 20'h80000, 1'b0);
    cyc("R8", 1'b0, 1'b1, 20'hC0000, 1'b0);
    cyc("R8", 1'b0, 1'b1, 20'h00100, 1'b1);
    // R10: reset during a strobed I/O access
    @(negedge clk);
    as_n = 1'b0; addr = 20'hFFFF5; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) begin as_n = 1'b1; rst_n = 1'b1; end
    idle(3);
    cyc("R10", 1'b0, 1'b1, 20'h00000, 1'b1);
    cyc("R10", 1'b0, 1'b1, 20'h40000, 1'b1);
    cyc("R10", 1'b0, 1'b1, 20'h00020, 1'b1);
    // clear again through a slow I/O access
    cyc("R4", 1'b0, 1'b1, 20'h80001, 1'b1);
    cyc("R4", 1'b0, 1'b0, 20'h00020, 1'b1);
    // sweep of mixed patterns
    for (int k = 0; k < 64; k++) begin
      logic [19:0] a;
      a = 20'(k * 20'h0C351 + (k << 14));
      cyc("R1", k[0], k[1], a, ~k[2] | ~k[3]);
    end
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule